// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

This is a 16-bit timer-counter with a companion 16-bit capture/reload register. It advances either once per machine cycle, when a strobe marks the cycle, or on falling edges of an external count pin. An edge on the count pin is recognised only when one machine-cycle sample is high and the next sample is low. Control inputs select one of four operating modes. In auto-reload mode an overflow reloads the counter from the companion register. In capture mode the counter wraps to zero and a trigger-pin edge copies the count into the companion register. In baud-generator mode an overflow reloads the counter and emits a tick for a serial port. When the run bit is clear the block is off.

Two sticky flags, overflow and external, feed one interrupt request. Only software clears them, through a small write port. The same write port also loads the counter and the companion register.

Modes (`crt_mode_e`): `MD_OFF`, `MD_RELOAD`, `MD_CAPTURE`, `MD_BAUD`. Each pin sampler is a two-state machine (`crt_det_e`):
- `DS_LOW` → `DS_HIGH` on a strobe that samples the pin high.
- `DS_HIGH` → `DS_LOW` on a strobe that samples the pin low. This transition issues the one-clock fall pulse.
- In any other case the state holds. After reset both samplers are in `DS_LOW`.

Top module: `cr_timer`

## Requirements
- R1: With `ctl_run` = 0 the block is off: the counter holds, no flag is set and no `baud_tick` is produced, whatever the other control bits hold.
- R2: With `ctl_run` = 1, either baud select at 1 gives baud-generator mode whatever `ctl_cap_sel` holds. With both baud selects at 0, `ctl_cap_sel` = 0 gives auto-reload mode and `ctl_cap_sel` = 1 gives capture mode. In baud mode a trigger does not copy into the companion register.
- R3: With `ctl_ext_cnt` = 0 and the block running, the counter adds one for every clock in which `cyc_stb` is high.
- R4: With `ctl_ext_cnt` = 1, the counter adds one only when a strobe samples `cnt_pin` low and the previous strobe sampled it high. The new value is visible from the clock after that strobe. Pin changes between strobes are not seen.
- R5: In auto-reload mode, an advance from 0xFFFF loads the counter from `reload` and sets `ovf_flag`.
- R6: In capture mode, an advance from 0xFFFF wraps the counter to 0x0000 and sets `ovf_flag`.
- R7: In capture mode with `ctl_ext_en` = 1, a sampled falling edge on `trg_pin` copies the counter into `reload` and sets `ext_flag`. With `ctl_ext_en` = 0 the edge has no effect.
- R8: In auto-reload mode with `ctl_ext_en` = 1, a sampled falling edge on `trg_pin` reloads the counter from `reload` and sets `ext_flag`.
- R9: In baud mode, an advance from 0xFFFF reloads the counter, drives `baud_tick` high for one clock, and leaves `ovf_flag` unchanged.
- R10: `irq` is the OR of `ovf_flag` and `ext_flag`. A flag stays set until a write to address 2, where data bit 0 clears `ovf_flag` and bit 1 clears `ext_flag`. A set in the same clock as a clear wins.
- R11: A write to address 0 loads the counter and a write to address 1 loads `reload`. Software writes take priority over hardware updates. Writes to address 3 change nothing.
- R12: After reset, `count`, `reload`, both flags, `irq` and `baud_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | One-clock strobe per machine cycle (sampling phase) |
| cnt_pin | input | 1 | External count input |
| trg_pin | input | 1 | External trigger input |
| ctl_run | input | 1 | Run enable |
| ctl_cap_sel | input | 1 | 1 = capture, 0 = auto-reload |
| ctl_baud_rx | input | 1 | Baud select, receive side |
| ctl_baud_tx | input | 1 | Baud select, transmit side |
| ctl_ext_en | input | 1 | Enables trigger-pin action |
| ctl_ext_cnt | input | 1 | 1 = count pin edges, 0 = count machine cycles |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 counter, 1 reload, 2 flag clear |
| wr_data | input | 16 | Write data |
| count | output | 16 | Counter value |
| reload | output | 16 | Capture/reload register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External trigger flag |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-clock pulse per baud-mode overflow |

## Verification
The assertions assume that `cyc_stb` marks the sampling instant, and that both pins change only between strobes. They also assume software writes are single-clock pulses.

The stimulus drives every input on the falling clock edge. Each strobe is one clock wide and followed by an idle clock, so pins are stable whenever they are sampled. Pin glitches are placed only between strobes. External counting is frozen by holding the count pin low while triggers are exercised, so the expected counter values stay exact.

// File: rtl/crt_pkg.sv
package crt_pkg;
    typedef enum logic [1:0] {
        MD_OFF     = 2'd0,
        MD_RELOAD  = 2'd1,
        MD_CAPTURE = 2'd2,
        MD_BAUD    = 2'd3
    } crt_mode_e;

    typedef enum logic {
        DS_LOW  = 1'b0,
        DS_HIGH = 1'b1
    } crt_det_e;

    localparam logic [1:0] WA_COUNT  = 2'd0;
    localparam logic [1:0] WA_RELOAD = 2'd1;
    localparam logic [1:0] WA_CLEAR  = 2'd2;
endpackage

// File: rtl/crt_mode_sel.sv
module crt_mode_sel
    import crt_pkg::*;
(
    input  logic      run,
    input  logic      cap_sel,
    input  logic      baud_rx,
    input  logic      baud_tx,
    output crt_mode_e mode
);
    always_comb begin
        if (!run) begin
            mode = MD_OFF;
        end else if (baud_rx || baud_tx) begin
            mode = MD_BAUD;
        end else if (cap_sel) begin
            mode = MD_CAPTURE;
        end else begin
            mode = MD_RELOAD;
        end
    end
endmodule

// File: rtl/crt_edge_det.sv
module crt_edge_det
    import crt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic pin,
    output logic fall
);
    crt_det_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DS_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        fall = 1'b0;
        if (stb) begin
            unique case (st_q)
                DS_LOW: begin
                    if (pin) st_d = DS_HIGH;
                end
                DS_HIGH: begin
                    if (!pin) begin
                        st_d = DS_LOW;
                        fall = 1'b1;
                    end
                end
                default: st_d = DS_LOW;
            endcase
        end
    end

    AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R4
endmodule

// File: rtl/crt_flag_reg.sv
module crt_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q); // R10
endmodule

// File: rtl/cr_timer.sv
module cr_timer
    import crt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_stb,
    input  logic         cnt_pin,
    input  logic         trg_pin,
    input  logic         ctl_run,
    input  logic         ctl_cap_sel,
    input  logic         ctl_baud_rx,
    input  logic         ctl_baud_tx,
    input  logic         ctl_ext_en,
    input  logic         ctl_ext_cnt,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         ovf_flag,
    output logic         ext_flag,
    output logic         irq,
    output logic         baud_tick
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam int NPIN = 2;
    localparam int NFLG = 2;

    crt_mode_e mode;
    logic [NPIN-1:0] pins, falls;
    logic [NFLG-1:0] fset, fclr, fq;
    logic cnt_fall, trg_fall;
    logic inc, wrap, trig;
    logic wr_cnt, wr_rld, wr_clr;
    logic [W-1:0] cnt_q, cnt_d, cap_q, cap_d;
    logic tick_q;

    crt_mode_sel u_mode (
        .run     (ctl_run),
        .cap_sel (ctl_cap_sel),
        .baud_rx (ctl_baud_rx),
        .baud_tx (ctl_baud_tx),
        .mode    (mode)
    );

    assign pins = {trg_pin, cnt_pin};

    for (genvar g = 0; g < NPIN; g++) begin : g_det
        crt_edge_det u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (cyc_stb),
            .pin   (pins[g]),
            .fall  (falls[g])
        );
    end

    assign cnt_fall = falls[0];
    assign trg_fall = falls[1];

    assign wr_cnt = wr_en && (wr_addr == WA_COUNT);
    assign wr_rld = wr_en && (wr_addr == WA_RELOAD);
    assign wr_clr = wr_en && (wr_addr == WA_CLEAR);

    assign inc  = (mode != MD_OFF) && (ctl_ext_cnt ? cnt_fall : cyc_stb);
    assign wrap = inc && (cnt_q == MAXV) && !wr_cnt;
    assign trig = ctl_ext_en && trg_fall && (mode != MD_OFF);

    always_comb begin
        cnt_d = cnt_q;
        if (wr_cnt) begin
            cnt_d = wr_data;
        end else if (trig && mode == MD_RELOAD) begin
            cnt_d = cap_q;
        end else if (inc) begin
            if (cnt_q == MAXV && (mode == MD_RELOAD || mode == MD_BAUD)) begin
                cnt_d = cap_q;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        cap_d = cap_q;
        if (wr_rld) begin
            cap_d = wr_data;
        end else if (trig && mode == MD_CAPTURE) begin
            cap_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cap_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            cap_q  <= cap_d;
            tick_q <= wrap && (mode == MD_BAUD);
        end
    end

    assign fset[0] = wrap && (mode == MD_CAPTURE || (mode == MD_RELOAD && !trig));
    assign fset[1] = trig;
    assign fclr[0] = wr_clr && wr_data[0];
    assign fclr[1] = wr_clr && wr_data[1];

    for (genvar f = 0; f < NFLG; f++) begin : g_flag
        crt_flag_reg u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (fset[f]),
            .clr   (fclr[f]),
            .q     (fq[f])
        );
    end

    assign count     = cnt_q;
    assign reload    = cap_q;
    assign ovf_flag  = fq[0];
    assign ext_flag  = fq[1];
    assign irq       = fq[0] | fq[1];
    assign baud_tick = tick_q;

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OFF && !wr_cnt) |=> $stable(cnt_q)); // R1
    AST_RELOAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RELOAD && wrap && !trig) |=> (cnt_q == $past(cap_q)) && fq[0]); // R5
    AST_CAPTURE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_CAPTURE && wrap) |=> (cnt_q == '0) && fq[0]); // R6
    AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_CAPTURE && trig && !wr_rld) |=> (cap_q == $past(cnt_q)) && fq[1]); // R7
    AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_BAUD && !fq[0]) |=> !fq[0]); // R9
    AST_TICK_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> $past(mode == MD_BAUD)); // R9
endmodule

// File: tb/cr_timer_bench.sv
module cr_timer_bench;
    typedef struct packed {
        logic        run;
        logic        cap_sel;
        logic        brx;
        logic        btx;
        logic [15:0] start;
        logic [15:0] rld;
        logic [3:0]  nstb;
        logic [15:0] exp_cnt;
        logic        exp_ovf;
        logic [1:0]  exp_ticks;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0000, 4'd5, 16'h1234, 1'b0, 2'd0}, // R1
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFE, 16'h8000, 4'd3, 16'h8001, 1'b1, 2'd0}, // R5
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 4'd2, 16'h0001, 1'b1, 2'd0}, // R6
        '{1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFE, 16'hFFF0, 4'd4, 16'hFFF2, 1'b0, 2'd1}, // R9 R2
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFE, 16'hFFFE, 4'd5, 16'hFFFF, 1'b0, 2'd2}, // R9
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0010, 16'h0000, 4'd7, 16'h0017, 1'b0, 2'd0}, // R3
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0001, 4'd3, 16'hFFFF, 1'b0, 2'd0}  // R1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_stb = 1'b0, cnt_pin = 1'b0, trg_pin = 1'b0;
    logic ctl_run = 1'b0, ctl_cap_sel = 1'b0, ctl_baud_rx = 1'b0, ctl_baud_tx = 1'b0;
    logic ctl_ext_en = 1'b0, ctl_ext_cnt = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] count, reload;
    logic ovf_flag, ext_flag, irq, baud_tick;
    int checks = 0;
    int errs = 0;
    int ticks = 0;

    always #2 clk = ~clk;

    cr_timer u_cr_timer (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cnt_pin(cnt_pin), .trg_pin(trg_pin),
        .ctl_run(ctl_run), .ctl_cap_sel(ctl_cap_sel), .ctl_baud_rx(ctl_baud_rx),
        .ctl_baud_tx(ctl_baud_tx), .ctl_ext_en(ctl_ext_en), .ctl_ext_cnt(ctl_ext_cnt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .reload(reload),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq), .baud_tick(baud_tick)
    );

    always @(negedge clk) if (rst_n && baud_tick) ticks++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        cyc_stb = 1'b1;
        @(negedge clk);
        cyc_stb = 1'b0;
    endtask

    task automatic set_ctl(input logic r, input logic c, input logic rx, input logic tx);
        @(negedge clk);
        ctl_run = r; ctl_cap_sel = c; ctl_baud_rx = rx; ctl_baud_tx = tx;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset values
        chk("R12 count", count, 0);
        chk("R12 reload", reload, 0);
        chk("R12 flags", {ovf_flag, ext_flag, irq, baud_tick}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            int t0;
            set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
            wr(2'd2, 16'h0003);
            wr(2'd0, TBL[i].start);
            wr(2'd1, TBL[i].rld);
            set_ctl(TBL[i].run, TBL[i].cap_sel, TBL[i].brx, TBL[i].btx);
            t0 = ticks;
            for (int s = 0; s < int'(TBL[i].nstb); s++) strobe();
            @(negedge clk);
            chk("R1 R3 R5 R6 R9 table count", count, TBL[i].exp_cnt);
            chk("R5 R6 R9 table ovf_flag", ovf_flag, TBL[i].exp_ovf);
            chk("R10 table irq", irq, TBL[i].exp_ovf);
            chk("R2 R9 table ticks", ticks - t0, TBL[i].exp_ticks);
        end

        // R4 external count edges
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        ctl_ext_cnt = 1'b1;
        cnt_pin = 1'b0;
        wr(2'd0, 16'h0000);
        cnt_pin = 1'b1; strobe();
        chk("R4 high sample alone", count, 0);
        cnt_pin = 1'b0; strobe();
        chk("R4 high then low", count, 1);
        strobe();
        chk("R4 steady low", count, 1);
        @(negedge clk); cnt_pin = 1'b1;
        @(negedge clk); cnt_pin = 1'b0;
        strobe();
        chk("R4 glitch between strobes", count, 1);
        cnt_pin = 1'b1; strobe(); strobe();
        cnt_pin = 1'b0; strobe();
        chk("R4 second edge", count, 2);

        // R7 capture with ext enable, counter frozen (pin low)
        wr(2'd2, 16'h0003);
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        ctl_ext_en = 1'b1;
        wr(2'd0, 16'h4321);
        wr(2'd1, 16'h0000);
        trg_pin = 1'b1; strobe();
        trg_pin = 1'b0; strobe();
        chk("R7 captured", reload, 16'h4321);
        chk("R7 ext_flag", ext_flag, 1);
        chk("R10 irq from ext", irq, 1);
        strobe(); strobe();
        chk("R10 ext_flag sticky", ext_flag, 1);
        wr(2'd2, 16'h0001);
        chk("R10 clear ovf bit keeps ext", ext_flag, 1);
        wr(2'd2, 16'h0002);
        chk("R10 ext cleared", {ext_flag, irq}, 0);

        // R7 ext enable low: ignored
        ctl_ext_en = 1'b0;
        wr(2'd0, 16'h0777);
        trg_pin = 1'b1; strobe();
        trg_pin = 1'b0; strobe();
        chk("R7 disabled reload", reload, 16'h4321);
        chk("R7 disabled ext_flag", ext_flag, 0);

        // R8 reload-mode trigger
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        ctl_ext_en = 1'b1;
        wr(2'd1, 16'h0A0A);
        wr(2'd0, 16'h1111);
        trg_pin = 1'b1; strobe();
        trg_pin = 1'b0; strobe();
        chk("R8 counter reloaded", count, 16'h0A0A);
        chk("R8 ext_flag", ext_flag, 1);
        wr(2'd2, 16'h0003);

        // R2 baud overrides capture select: trigger does not capture
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0);
        wr(2'd1, 16'h5555);
        wr(2'd0, 16'h2222);
        trg_pin = 1'b1; strobe();
        trg_pin = 1'b0; strobe();
        chk("R2 baud no capture", reload, 16'h5555);
        chk("R2 baud counter", count, 16'h2222);
        wr(2'd2, 16'h0003);
        ctl_ext_en = 1'b0;

        // R11 write priority and unused address
        ctl_ext_cnt = 1'b0;
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0100; cyc_stb = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cyc_stb = 1'b0;
        chk("R11 write beats increment", count, 16'h0100);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        wr(2'd3, 16'hBEEF);
        chk("R11 addr3 count", count, 16'h0100);
        chk("R11 addr3 reload", reload, 16'h5555);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule